// File: doc/BRIEF.md
# Credit-Gated Crossbar Switch Allocator

This block decides, every cycle, which input of a router crossbar may send a flit to each output port. Every requesting input already owns a virtual channel on the next hop. It states the output port and the downstream VC it targets, the flit payload, and whether the flit ends its packet. A request competes only while its downstream VC still has buffer space. The block keeps one credit counter per downstream VC: a grant takes one credit, and a credit pulse from the next hop gives one back.

Each output has its own round-robin arbiter. The winners drive a one-hot crossbar select and the payload mux. The parameter `COMBINE_ST` chooses where traversal happens. With a value of 1 the crossbar is driven in the grant cycle. With a value of 0 each output registers its select and data, so the flit crosses one cycle later. A per-output state machine does this, with states `XS_IDLE` and `XS_DRIVE`. The transition idle→drive happens on a cycle with a grant. The transition drive→idle happens on a cycle without one. drive→drive and idle→idle keep the state.

A tail flit that wins releases its downstream VC, and the block reports this on `vc_freed`. `COUPLE_FREE` chooses how soon a VC allocator sees the release: the same cycle (1) or one cycle later (0).

Top module: `sa_credit_alloc`

## Requirements
- R1: After reset every output has `xvld` low, `xsel` zero and `xdat` zero. `vc_freed` is zero. Every downstream VC counter holds `CRED_MAX` credits.
- R2: A request is granted only if its downstream VC held at least one credit at the start of the cycle. A credit returned in the same cycle does not make it eligible until the next cycle.
- R3: Each grant removes one credit from its downstream VC. Each `crd_ret` pulse adds one, and a pulse arriving at `CRED_MAX` is dropped. A VC drained to zero is granted again after a return.
- R4: Each output arbitrates round-robin. Its search starts at the input after that output's last winner, wrapping from N_IN-1 to 0. After reset the search starts at input 0.
- R5: For output o, `xsel[o*N_IN +: N_IN]` is one-hot when that output carries a flit and all zero otherwise. `xvld[o]` is high exactly when it carries a flit.
- R6: With `COMBINE_ST`=1, `xsel`/`xvld`/`xdat` reflect the grants of the same cycle. With `COMBINE_ST`=0 they reflect the grants of the previous cycle, with the payload captured in the grant cycle. `xdat[o*DW +: DW]` is the granted input's `req_dat` slice, or zero with no flit.
- R7: With `COUPLE_FREE`=1, `vc_freed` pulses in the cycle of the tail grant. With `COUPLE_FREE`=0 it pulses one cycle later.
- R8: `vc_freed` bit `o*N_VC+v` pulses only for a granted request with `req_tail` set, targeting port o and VC v.
- R9: An input with `req_vld` low is neither granted nor frees a VC, whatever its other request fields hold.
- R10: `gnt_o[i]` is high when input i wins its output. Different outputs are granted to different inputs in the same cycle, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | N_IN | Request valid per input |
| req_port | input | N_IN*OW | Target output port per input |
| req_vc | input | N_IN*VW | Target downstream VC per input |
| req_tail | input | N_IN | Flit is the last of its packet |
| req_dat | input | N_IN*DW | Flit payload per input |
| crd_ret | input | N_OUT*N_VC | Credit return pulse, bit o*N_VC+v |
| gnt_o | output | N_IN | Grant per input in the allocation cycle |
| xsel | output | N_OUT*N_IN | Crossbar select, bit o*N_IN+i |
| xdat | output | N_OUT*DW | Crossbar output payload per port |
| xvld | output | N_OUT | Output port carries a flit |
| vc_freed | output | N_OUT*N_VC | Downstream VC released by a tail flit |

## Verification
The bench builds two copies with four inputs, two ports, two VCs per port and only two credits per VC. One copy has split traversal and delayed release (0,0). The other has both stages merged (1,1). Both get the same stimulus. The small credit depth drains a VC within two grants, so refusal, same-cycle return, refill and pointer wrap all happen in a short sequence. Comparing the two copies against one expectation shows the one-cycle offset of traversal and of release.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic {
        XS_IDLE  = 1'b0,
        XS_DRIVE = 1'b1
    } xs_state_e;
endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;

    // search starts at ptr and wraps around
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (gnt[k]) ptr <= (k == N - 1) ? '0 : PW'(k + 1);
            end
        end
    end
endmodule

// File: rtl/sa_credit_bank.sv
module sa_credit_bank #(
    parameter int NQ       = 4,
    parameter int CRED_MAX = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] take,
    input  logic [NQ-1:0] give,
    output logic [NQ-1:0] avail
);
    localparam int CW = $clog2(CRED_MAX + 1);

    for (genvar q = 0; q < NQ; q++) begin : g_vc
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= CW'(CRED_MAX);
            end else begin
                unique case ({take[q], give[q]})
                    2'b10:   cnt <= cnt - 1'b1;
                    2'b01:   if (cnt < CW'(CRED_MAX)) cnt <= cnt + 1'b1;
                    default: cnt <= cnt;
                endcase
            end
        end

        assign avail[q] = (cnt != '0);
    end
endmodule

// File: rtl/sa_xbar_port.sv
module sa_xbar_port
    import sa_pkg::*;
#(
    parameter int N       = 4,
    parameter int DW      = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    sel,
    input  logic [N*DW-1:0] din,
    output logic [N-1:0]    xsel,
    output logic [DW-1:0]   xdat,
    output logic            xvld
);
    logic [DW-1:0] mux_d;

    always_comb begin
        mux_d = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) mux_d = mux_d | din[i*DW +: DW];
        end
    end

    if (REG_OUT) begin : g_reg
        xs_state_e     st;
        logic [N-1:0]  sel_q;
        logic [DW-1:0] dat_q;

        // state register: drive in the cycle after any grant
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st    <= XS_IDLE;
                sel_q <= '0;
                dat_q <= '0;
            end else begin
                st    <= (|sel) ? XS_DRIVE : XS_IDLE;
                sel_q <= sel;
                dat_q <= mux_d;
            end
        end

        // outputs per state
        always_comb begin
            unique case (st)
                XS_IDLE: begin
                    xsel = '0;
                    xdat = '0;
                    xvld = 1'b0;
                end
                XS_DRIVE: begin
                    xsel = sel_q;
                    xdat = dat_q;
                    xvld = 1'b1;
                end
                default: begin
                    xsel = '0;
                    xdat = '0;
                    xvld = 1'b0;
                end
            endcase
        end
    end else begin : g_comb
        assign xsel = sel;
        assign xdat = mux_d;
        assign xvld = |sel;
    end
endmodule

// File: rtl/sa_credit_alloc.sv
module sa_credit_alloc #(
    parameter int  N_IN        = 4,
    parameter int  N_OUT       = 2,
    parameter int  N_VC        = 2,
    parameter int  CRED_MAX    = 4,
    parameter int  DW          = 32,
    parameter bit  COMBINE_ST  = 1'b0,
    parameter bit  COUPLE_FREE = 1'b0,
    localparam int OW          = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int VW          = (N_VC > 1) ? $clog2(N_VC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_IN-1:0]       req_vld,
    input  logic [N_IN*OW-1:0]    req_port,
    input  logic [N_IN*VW-1:0]    req_vc,
    input  logic [N_IN-1:0]       req_tail,
    input  logic [N_IN*DW-1:0]    req_dat,
    input  logic [N_OUT*N_VC-1:0] crd_ret,
    output logic [N_IN-1:0]       gnt_o,
    output logic [N_OUT*N_IN-1:0] xsel,
    output logic [N_OUT*DW-1:0]   xdat,
    output logic [N_OUT-1:0]      xvld,
    output logic [N_OUT*N_VC-1:0] vc_freed
);
    localparam int NQ = N_OUT * N_VC;

    logic [NQ-1:0]   tsel [N_IN];
    logic [NQ-1:0]   crd_ok;
    logic [NQ-1:0]   take;
    logic [NQ-1:0]   tail_take;
    logic [N_IN-1:0] elig [N_OUT];
    logic [N_IN-1:0] win  [N_OUT];

    // one-hot downstream VC targeted by each input
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            tsel[i] = '0;
            for (int q = 0; q < NQ; q++) begin
                if (req_port[i*OW +: OW] == OW'(q / N_VC) &&
                    req_vc[i*VW +: VW] == VW'(q % N_VC))
                    tsel[i][q] = 1'b1;
            end
        end
    end

    // eligibility per output: valid, aimed here, credit available
    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            for (int i = 0; i < N_IN; i++) begin
                elig[o][i] = req_vld[i] &&
                             |(tsel[i][o*N_VC +: N_VC] & crd_ok[o*N_VC +: N_VC]);
            end
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        sa_rr_arb #(.N(N_IN)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (elig[o]),
            .gnt   (win[o])
        );

        sa_xbar_port #(
            .N       (N_IN),
            .DW      (DW),
            .REG_OUT (!COMBINE_ST)
        ) u_xp (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (win[o]),
            .din   (req_dat),
            .xsel  (xsel[o*N_IN +: N_IN]),
            .xdat  (xdat[o*DW +: DW]),
            .xvld  (xvld[o])
        );
    end

    always_comb begin
        gnt_o     = '0;
        take      = '0;
        tail_take = '0;
        for (int o = 0; o < N_OUT; o++) gnt_o = gnt_o | win[o];
        for (int i = 0; i < N_IN; i++) begin
            if (gnt_o[i]) begin
                take = take | tsel[i];
                if (req_tail[i]) tail_take = tail_take | tsel[i];
            end
        end
    end

    sa_credit_bank #(
        .NQ       (NQ),
        .CRED_MAX (CRED_MAX)
    ) u_crd (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .give  (crd_ret),
        .avail (crd_ok)
    );

    if (COUPLE_FREE) begin : g_free_now
        assign vc_freed = tail_take;
    end else begin : g_free_late
        always_ff @(posedge clk) begin
            if (!rst_n) vc_freed <= '0;
            else        vc_freed <= tail_take;
        end
    end
endmodule

// File: rtl/sa_credit_alloc_chk.sv
module sa_credit_alloc_chk #(
    parameter int N_IN        = 4,
    parameter int N_OUT       = 2,
    parameter int N_VC        = 2,
    parameter bit COMBINE_ST  = 1'b0,
    parameter bit COUPLE_FREE = 1'b0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_IN-1:0]       req_vld,
    input logic [N_IN-1:0]       req_tail,
    input logic [N_IN-1:0]       gnt_o,
    input logic [N_OUT*N_IN-1:0] xsel,
    input logic [N_OUT-1:0]      xvld,
    input logic [N_OUT*N_VC-1:0] vc_freed
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_port
        // R5
        xsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(xsel[o*N_IN +: N_IN]));
    end

    // R9
    gnt_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_vld) == '0);

    // R6
    same_cycle_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        COMBINE_ST |-> $countones(xvld) == $countones(gnt_o));

    // R6
    next_cycle_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !COMBINE_ST |=> $countones(xvld) == $countones($past(gnt_o)));

    // R8
    free_needs_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!COUPLE_FREE && (gnt_o & req_tail) == '0) |=> vc_freed == '0);

    // R7
    free_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (COUPLE_FREE && (gnt_o & req_tail) == '0) |-> vc_freed == '0);
endmodule

bind sa_credit_alloc sa_credit_alloc_chk #(
    .N_IN        (N_IN),
    .N_OUT       (N_OUT),
    .N_VC        (N_VC),
    .COMBINE_ST  (COMBINE_ST),
    .COUPLE_FREE (COUPLE_FREE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_tail (req_tail),
    .gnt_o    (gnt_o),
    .xsel     (xsel),
    .xvld     (xvld),
    .vc_freed (vc_freed)
);

// File: tb/sim_sa_credit_alloc.sv
`timescale 1ns/1ps
module sim_sa_credit_alloc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_vld = '0, req_port = '0, req_vc = '0, req_tail = '0;
    logic [31:0] req_dat = '0;
    logic [3:0] crd_ret = '0;

    logic [3:0]  g0, g1, f0, f1;
    logic [7:0]  s0, s1;
    logic [15:0] d0, d1;
    logic [1:0]  v0, v1;

    int checks = 0;
    int errors = 0;
    int seq = 0;

    typedef struct {
        logic [7:0]  sel;
        logic [15:0] dat;
        logic [1:0]  vld;
        logic [3:0]  fr;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    sa_credit_alloc #(.N_IN(4), .N_OUT(2), .N_VC(2), .CRED_MAX(2), .DW(8),
                      .COMBINE_ST(1'b0), .COUPLE_FREE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_port(req_port),
        .req_vc(req_vc), .req_tail(req_tail), .req_dat(req_dat), .crd_ret(crd_ret),
        .gnt_o(g0), .xsel(s0), .xdat(d0), .xvld(v0), .vc_freed(f0));

    sa_credit_alloc #(.N_IN(4), .N_OUT(2), .N_VC(2), .CRED_MAX(2), .DW(8),
                      .COMBINE_ST(1'b1), .COUPLE_FREE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_port(req_port),
        .req_vc(req_vc), .req_tail(req_tail), .req_dat(req_dat), .crd_ret(crd_ret),
        .gnt_o(g1), .xsel(s1), .xdat(d1), .xvld(v1), .vc_freed(f1));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // driver: one allocation cycle, checks merged copy now, queues split copy
    task automatic step(input logic [3:0] v, input logic [3:0] o, input logic [3:0] c,
                        input logic [3:0] t, input logic [3:0] r,
                        input logic [3:0] eg, input logic [3:0] ef, input string tag);
        exp_t e;
        @(negedge clk);
        seq++;
        req_vld = v; req_port = o; req_vc = c; req_tail = t; crd_ret = r;
        for (int i = 0; i < 4; i++) req_dat[i*8 +: 8] = 8'((i + 1) * 16 + (seq % 16));
        e.sel = '0; e.dat = '0; e.vld = '0; e.fr = ef;
        for (int i = 0; i < 4; i++) begin
            if (eg[i]) begin
                e.sel[o[i]*4 + i]   = 1'b1;
                e.vld[o[i]]         = 1'b1;
                e.dat[o[i]*8 +: 8]  = req_dat[i*8 +: 8];
            end
        end
        #2;
        chk(g0 === eg, tag, 32'(g0), 32'(eg));
        chk(g1 === eg, tag, 32'(g1), 32'(eg));
        chk(s1 === e.sel, "R5", 32'(s1), 32'(e.sel));
        chk(v1 === e.vld, "R5", 32'(v1), 32'(e.vld));
        chk(d1 === e.dat, "R6", 32'(d1), 32'(e.dat));
        chk(f1 === e.fr, "R7", 32'(f1), 32'(e.fr));
        expq.push_back(e);
    endtask

    // monitor: split copy shows last cycle's grants
    always @(posedge clk) begin
        #5;
        if (expq.size() > 0) begin
            exp_t m;
            m = expq.pop_front();
            chk(s0 === m.sel, "R5", 32'(s0), 32'(m.sel));
            chk(v0 === m.vld, "R5", 32'(v0), 32'(m.vld));
            chk(d0 === m.dat, "R6", 32'(d0), 32'(m.dat));
            chk(f0 === m.fr, "R8", 32'(f0), 32'(m.fr));
        end
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R1: idle outputs after reset
        chk(v0 === 2'b00 && s0 === 8'h00 && d0 === 16'h0, "R1", 32'({v0, s0}), 32'h0);
        chk(f0 === 4'h0, "R1", 32'(f0), 32'h0);
        chk(v1 === 2'b00 && f1 === 4'h0, "R1", 32'({v1, f1}), 32'h0);
        //    vld      port     vc       tail     ret      egnt     efree
        step(4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, "R1"); // full credits, start at input 0
        step(4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b0000, "R4");
        step(4'b0111, 4'b0100, 4'b0100, 4'b0100, 4'b0001, 4'b0100, 4'b1000, "R2"); // VC drained, return too late
        step(4'b1011, 4'b1000, 4'b0000, 4'b1000, 4'b0000, 4'b1001, 4'b0100, "R3"); // refilled VC granted
        step(4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0001, 4'b0000, 4'b0000, "R9");
        step(4'b1111, 4'b1100, 4'b1100, 4'b0010, 4'b0000, 4'b0110, 4'b0001, "R10");
        step(4'b1111, 4'b1100, 4'b1100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R3");
        step(4'b1111, 4'b1100, 4'b1100, 4'b0000, 4'b1000, 4'b0000, 4'b0000, "R2");
        step(4'b1111, 4'b1100, 4'b1100, 4'b0000, 4'b0000, 4'b1000, 4'b0000, "R4"); // pointer at input 3
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R9");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule